// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory. It runs on a fast system clock and treats the bus clock and data lines as slow inputs. Each line passes through a synchroniser, and the block finds bus-clock edges and START and STOP conditions from the synchronised samples. It frames device-address, word-address and data bytes. It drives acknowledge bits and read data through an open-drain output enable: a 1 on `sda_oe` pulls the data line low.

Write data goes into a small page buffer that holds the most recent bytes. The buffer is copied into an internal 256-byte array when the master issues STOP. After the copy, a timed programming period follows. During that period the slave does not acknowledge anything.

Reads return bytes from an internal pointer that advances after each byte. A random read is done by sending a word address in a write command and then a repeated START with a read command. A read ends when the master answers a byte with a NACK.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, the bus is released, and every array location reads back as 0xFF.
- R2: SDA falling while SCL is high (START, from an idle bus with both lines high) begins a command. SDA rising while SCL is high (STOP) ends any transfer and releases SDA on the next clock.
- R3: The slave changes its SDA drive from released to pulling low only while SCL is low.
- R4: The first byte after START holds 1010 in bits 7:4, `dev_sel` in bits 3:1 and the direction in bit 0 (1 = read). On a match, and for every later byte of a write, the slave holds SDA low through the whole high phase of the ninth clock.
- R5: While a programming period runs, the slave gives no acknowledge at all, including to its own address.
- R6: In a write, the byte after the address is the word address. At STOP, the buffered data bytes are stored at consecutive locations starting there, wrapping from 255 to 0.
- R7: Only the last PAGE_DEPTH (16) data bytes of a write are kept. Each extra byte evicts the oldest one, and the kept bytes are stored in arrival order from the word address.
- R8: The programming period lasts BUSY_CYCLES system clocks after the array update. Once it ends, the device address is acknowledged again.
- R9: During a read the pointer advances by one after each byte sent and wraps from 255 to 0.
- R10: After a byte answered with NACK, the slave keeps SDA released through any further clocks until the next START.
- R11: A repeated START restarts byte framing but keeps the pointer, so a word-address write followed by a repeated START read returns data from that word address.
- R12: A mismatched device address gets no acknowledge. The rest of that transfer is ignored and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND of all drivers) |
| dev_sel | input | 3 | Strapped low bits of the device address |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
The hardest situation to reach from the ports is a command arriving inside the programming period. A write has to finish with STOP, and the next START must come before BUSY_CYCLES clocks have run out. The stimulus therefore issues the STOP of a one-byte write and at once sends two address bytes back to back, each inside the window, and expects no acknowledge to either. It then waits out the period and reads the byte back to confirm that the slave answers again. Overflow of the page buffer is reached by writing twenty bytes and reading past the kept range. The pointer wrap is reached by writing and reading from address 0xFE.

// File: rtl/eep_pkg.sv
// Shared types for the two-wire serial EEPROM slave.
// Assumes: one-byte word addresses and byte-wide data.
package eep_pkg;
    // Bit-level protocol state of the slave
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK
    } bus_state_t;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        PH_DEV,
        PH_WORD,
        PH_DATA
    } phase_t;
endpackage

// File: rtl/eep_bus_sync.sv
// Synchronises the bus clock and data lines into the system clock domain
// and flags bus-clock edges and START/STOP conditions.
// Assumes: STAGES >= 2, and bus phases last several system clocks.
module eep_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Synchroniser chains; reset to the idle (high) bus level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Edge and condition flags from the last two synchronised samples
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/eep_page_buf.sv
// Circular page buffer that keeps the newest DEPTH bytes of a write.
// A push into a full buffer evicts the oldest entry. rd_idx counts from
// the oldest kept entry. Assumes: DEPTH is a power of two; storage
// cells carry no reset, since only pushed cells are ever read.
module eep_page_buf #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count
);
    logic [DW-1:0] cells [DEPTH];
    logic [IW-1:0] wr_ptr;
    logic [IW-1:0] oldest;

    // Write pointer and fill count, saturating at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (push) begin
            wr_ptr <= wr_ptr + IW'(1);
            if (count != CW'(DEPTH)) count <= count + CW'(1);
        end
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (push && !clr) cells[wr_ptr] <= din;
    end

    // Read relative to the oldest kept entry
    always_comb begin
        oldest  = wr_ptr - IW'(count);
        rd_data = cells[oldest + rd_idx];
    end

    // R7
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R7
    full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && count == CW'(DEPTH)) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/eep_mem_array.sv
// Byte-wide storage array with one synchronous write port and one
// combinational read port. Resets to the erased value.
// Assumes: 2**AW entries stay small (a few hundred).
module eep_mem_array #(
    parameter int          AW        = 8,
    parameter int          DW        = 8,
    parameter logic [7:0]  ERASE_VAL = 8'hFF,
    localparam int         NWORDS    = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] words [NWORDS];

    // Erase on reset, otherwise accept one write per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) words[i] <= DW'(ERASE_VAL);
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end

    // Asynchronous read
    assign rdata = words[raddr];
endmodule

// File: rtl/eeprom_i2c_slave.sv
// Two-wire serial EEPROM slave. It frames bytes from synchronised bus
// samples and acknowledges by pulling SDA low. Write bytes are buffered
// and copied into the array after STOP, then a timed programming period
// runs during which no byte is acknowledged. Reads are served from an
// auto-incrementing pointer. Assumes: 7-bit addressing, one master, no
// clock stretching, each bus phase lasting several system clocks.
module eeprom_i2c_slave
    import eep_pkg::*;
#(
    parameter int         PAGE_DEPTH  = 16,
    parameter int         BUSY_CYCLES = 3000,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_TYPE    = 4'b1010,
    localparam int        AW          = 8,
    localparam int        IW          = $clog2(PAGE_DEPTH),
    localparam int        CW          = $clog2(PAGE_DEPTH + 1),
    localparam int        BW          = $clog2(BUSY_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel,
    output logic       sda_oe
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    bus_state_t    state;
    phase_t        phase;
    logic [7:0]    shreg;
    logic [3:0]    bitcnt;
    logic          rw;
    logic [7:0]    txreg;
    logic          m_acked;
    logic [AW-1:0] ptr;
    logic [AW-1:0] wbase;
    logic          oe_r;

    logic          commit_on;
    logic [CW-1:0] cidx;
    logic [BW-1:0] busy_cnt;
    logic          busy;

    logic          byte_done, dev_hit, buf_push, buf_clr, commit_last;
    logic [CW-1:0] buf_cnt;
    logic [7:0]    buf_rdata;
    logic [AW-1:0] mem_waddr;
    logic [7:0]    mem_rdata;

    eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    eep_page_buf #(.DEPTH(PAGE_DEPTH), .DW(8)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .push(buf_push),
        .din(shreg), .rd_idx(cidx[IW-1:0]), .rd_data(buf_rdata),
        .count(buf_cnt)
    );

    eep_mem_array #(.AW(AW), .DW(8), .ERASE_VAL(8'hFF)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(commit_on), .waddr(mem_waddr),
        .wdata(buf_rdata), .raddr(ptr), .rdata(mem_rdata)
    );

    // Byte-level events decoded from the protocol state
    always_comb begin
        byte_done   = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
        busy        = commit_on || (busy_cnt != '0);
        dev_hit     = (shreg[7:1] == {DEV_TYPE, dev_sel}) && !busy;
        buf_push    = byte_done && (phase == PH_DATA);
        commit_last = commit_on && (cidx == buf_cnt - CW'(1));
        buf_clr     = (byte_done && (phase == PH_WORD)) || commit_last;
        mem_waddr   = wbase + AW'(cidx);
        sda_oe      = oe_r;
    end

    // Commit engine: copy buffer to array after STOP, then time the busy period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_on <= 1'b0;
            cidx      <= '0;
            busy_cnt  <= '0;
        end else if (commit_on) begin
            if (commit_last) begin
                commit_on <= 1'b0;
                busy_cnt  <= BW'(BUSY_CYCLES);
            end else begin
                cidx <= cidx + CW'(1);
            end
        end else if (busy_cnt != '0) begin
            busy_cnt <= busy_cnt - BW'(1);
        end else if (stop_det && (buf_cnt != '0)) begin
            commit_on <= 1'b1;
            cidx      <= '0;
        end
    end

    // Protocol engine: framing, acknowledge and read-data drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= PH_DEV;
            shreg   <= '0;
            bitcnt  <= '0;
            rw      <= 1'b0;
            txreg   <= '0;
            m_acked <= 1'b0;
            ptr     <= '0;
            wbase   <= '0;
            oe_r    <= 1'b0;
        end else if (stop_det) begin
            state <= ST_IDLE;
            oe_r  <= 1'b0;
        end else if (start_det) begin
            state  <= ST_RX;
            phase  <= PH_DEV;
            bitcnt <= '0;
            oe_r   <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && bitcnt != 4'd8) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        case (phase)
                            PH_DEV: begin
                                if (dev_hit) begin
                                    rw    <= shreg[0];
                                    state <= ST_ACK;
                                    oe_r  <= 1'b1;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            PH_WORD: begin
                                ptr   <= shreg;
                                wbase <= shreg;
                                state <= ST_ACK;
                                oe_r  <= 1'b1;
                            end
                            default: begin
                                state <= ST_ACK;
                                oe_r  <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (phase == PH_DEV && rw) begin
                            state <= ST_TX;
                            txreg <= mem_rdata;
                            oe_r  <= ~mem_rdata[7];
                        end else begin
                            state <= ST_RX;
                            oe_r  <= 1'b0;
                            phase <= (phase == PH_DEV) ? PH_WORD : PH_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            state <= ST_TXACK;
                            oe_r  <= 1'b0;
                            ptr   <= ptr + AW'(1);
                        end else begin
                            txreg  <= {txreg[6:0], 1'b0};
                            oe_r   <= ~txreg[6];
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        m_acked <= ~sda_s;
                    end else if (scl_fall) begin
                        bitcnt <= '0;
                        if (m_acked) begin
                            state <= ST_TX;
                            txreg <= mem_rdata;
                            oe_r  <= ~mem_rdata[7];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    oe_r <= 1'b0;
                end
            endcase
        end
    end

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
    // R3
    drive_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s));
    // R5
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);
    // R8
    busy_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - BW'(1)));
    // R9
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && scl_fall && bitcnt == 4'd7 && ptr == 8'hFF)
        |=> (ptr == 8'h00));
endmodule

// File: tb/eeprom_i2c_slave_test.sv
module eeprom_i2c_slave_test;
    localparam int BUSY = 3000;
    localparam int H    = 20;
    localparam int Q    = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] sel = 3'b101;
    logic       sda_oe;
    logic       sda_line;
    assign sda_line = m_sda & ~sda_oe;

    eeprom_i2c_slave #(.BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .dev_sel(sel), .sda_oe(sda_oe)
    );

    always #5 clk = ~clk;

    int         total = 0;
    int         bad = 0;
    int         r3_viol = 0;
    logic       oe_prev = 1'b0;
    logic [7:0] exp_mem [256];
    logic [7:0] wbuf [32];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R3 monitor: pull-low must never begin while the bus clock is high
    always @(negedge clk) begin
        if (rst_n && sda_oe && !oe_prev && m_scl) r3_viol++;
        oe_prev <= sda_oe;
    end

    task automatic start_c();
        m_sda = 1'b1; wait_clk(H);
        m_scl = 1'b1; wait_clk(H);
        m_sda = 1'b0; wait_clk(H);
        m_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic stop_c();
        m_sda = 1'b0; wait_clk(H);
        m_scl = 1'b1; wait_clk(H);
        m_sda = 1'b1; wait_clk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit a1, a2;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_clk(H);
            m_scl = 1'b1; wait_clk(H);
            m_scl = 1'b0; wait_clk(Q);
        end
        m_sda = 1'b1; wait_clk(H);
        m_scl = 1'b1; wait_clk(H/4);
        a1 = !sda_line; wait_clk(H/2);
        a2 = !sda_line; wait_clk(H - H/4 - H/2);
        m_scl = 1'b0; wait_clk(Q);
        acked = a1 && a2;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_clk(H);
            m_scl = 1'b1; wait_clk(H/2);
            b = {b[6:0], sda_line}; wait_clk(H/2);
            m_scl = 1'b0;
        end
        wait_clk(Q);
        m_sda = mack ? 1'b0 : 1'b1; wait_clk(H);
        m_scl = 1'b1; wait_clk(H);
        m_scl = 1'b0; wait_clk(Q);
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] dev_byte(input logic [2:0] s, input bit rd);
        return {4'b1010, s, rd};
    endfunction

    // Expected array update: keep the newest 16 bytes, store from word address
    function automatic void model_write(input logic [7:0] wa, input int n);
        int first = (n > 16) ? n - 16 : 0;
        for (int i = first; i < n; i++) exp_mem[8'(wa + 8'(i - first))] = wbuf[i];
    endfunction

    task automatic do_write(input logic [7:0] wa, input int n, input string req, input bit settle);
        bit a;
        start_c();
        send_byte(dev_byte(sel, 1'b0), a); chk(a, {req, " R4 dev ack"}, a, 1);
        send_byte(wa, a);                  chk(a, {req, " R6 word ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);         chk(a, {req, " R4 data ack"}, a, 1);
        end
        stop_c();
        model_write(wa, n);
        if (settle) wait_clk(BUSY + 60);
    endtask

    task automatic do_read(input logic [7:0] wa, input int n, input string req);
        bit a;
        logic [7:0] d;
        start_c();
        send_byte(dev_byte(sel, 1'b0), a); chk(a, {req, " dev ack"}, a, 1);
        send_byte(wa, a);                  chk(a, {req, " word ack"}, a, 1);
        start_c();   // R11 repeated START
        send_byte(dev_byte(sel, 1'b1), a); chk(a, {req, " R11 read ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, d);
            chk(d == exp_mem[8'(wa + 8'(i))], {req, " data"}, d, exp_mem[8'(wa + 8'(i))]);
        end
        chk(sda_oe == 1'b0, {req, " R10 released after NACK"}, sda_oe, 0);
        stop_c();
    endtask

    initial begin
        bit a;
        logic [7:0] d;
        void'($urandom(32'd24681));
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
        wait_clk(5);
        chk(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        wait_clk(5);
        chk(sda_oe == 1'b0 && sda_line == 1'b1, "R1 bus released", sda_oe, 0);

        // R2 / R6 / R11: basic write then random read
        for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'h21 + 8'(i * 17));
        do_write(8'h10, 4, "R2", 1'b1);
        do_read(8'h0E, 7, "R6");   // R1: 0x0E, 0x0F, 0x14 still erased

        // R12: wrong device address is ignored
        start_c();
        send_byte(dev_byte(3'b001, 1'b0), a); chk(!a, "R12 no ack on mismatch", a, 0);
        send_byte(8'h10, a);                  chk(!a, "R12 word ignored", a, 0);
        send_byte(8'h55, a);                  chk(!a, "R12 data ignored", a, 0);
        stop_c();
        wait_clk(BUSY + 60);
        do_read(8'h10, 4, "R12");

        // R7: 20 bytes, only the last 16 survive
        for (int i = 0; i < 20; i++) wbuf[i] = 8'(8'h80 + 8'(i));
        do_write(8'h40, 20, "R7", 1'b1);
        do_read(8'h40, 20, "R7");

        // R5 / R8: commands inside the programming period
        wbuf[0] = 8'h3C;
        do_write(8'h80, 1, "R5", 1'b0);
        start_c();
        send_byte(dev_byte(sel, 1'b0), a); chk(!a, "R5 no ack while busy", a, 0);
        stop_c();
        start_c();
        send_byte(dev_byte(sel, 1'b1), a); chk(!a, "R8 still busy", a, 0);
        stop_c();
        wait_clk(BUSY);
        do_read(8'h80, 1, "R8");

        // R9: wrap of the pointer across 255
        for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
        do_write(8'hFE, 4, "R9", 1'b1);
        do_read(8'hFE, 4, "R9");

        // R10: after NACK, extra clocks see a released line
        start_c();
        send_byte(dev_byte(sel, 1'b0), a); chk(a, "R10 dev ack", a, 1);
        send_byte(8'h11, a);               chk(a, "R10 word ack", a, 1);
        start_c();
        send_byte(dev_byte(sel, 1'b1), a); chk(a, "R10 read ack", a, 1);
        recv_byte(1'b0, d);                chk(d == exp_mem[8'h11], "R10 data", d, exp_mem[8'h11]);
        for (int i = 0; i < 9; i++) begin
            wait_clk(H); m_scl = 1'b1; wait_clk(H/2);
            chk(sda_line == 1'b1, "R10 line high", sda_line, 1);
            wait_clk(H/2); m_scl = 1'b0;
        end
        wait_clk(Q);
        stop_c();

        // Random writes and reads against the model
        for (int k = 0; k < 4; k++) begin
            logic [7:0] wa = 8'($urandom);
            int n = 1 + int'($urandom % 18);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(wa, n, "R6 rnd", 1'b1);
            do_read(wa, (n > 16) ? 16 : n, "R7 rnd");
        end

        chk(r3_viol == 0, "R3 drive begins only with SCL low", r3_viol, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule